// File: doc/BRIEF.md
# Circular Buffer Pointer and Threshold Tracker

This block keeps the pointer state of one circular byte buffer used by a streaming DMA engine. It works either on the draining side of an output stream or on the filling side of an input stream. Software sets the buffer bounds, both pointers and a threshold. The hardware side then asks, one request at a time, to move the pointer it owns forward by a fixed byte step. Each pointer carries a lap flag in its top bit, so a full buffer and an empty one can be told apart without a spare slot.

From the two pointers the block derives the filled byte count, the free byte count, and full and empty flags. It refuses a request that would run past the data (output side) or into unread data (input side), and reports that refusal as an error pulse. When the watched byte count (free on the output side, filled on the input side) goes above the threshold, it sends one event pulse. It then stays quiet until software arms it again. Software starts a new period by rewriting one pointer from the other.

Top module: `rbuf_ptr_mark`

## Requirements
- R1: After reset, both pointers, both bounds and the threshold are zero and the event logic is disarmed. The block therefore shows empty, level 0 and no event until software arms it.
- R2: Configuration writes use `cfg_sel`: 0 = first byte address (base), 1 = last byte address, 2 = read pointer, 3 = write pointer, 4 = threshold. Bit 31 of the base and last writes is dropped, and so are the low 8 bits of a threshold write (the threshold is a whole multiple of 256). Level = write address − read address when the lap flags (bit 31) match, and (last − base + 1) − (read address − write address) when they differ. Free = size − level. Empty means the pointers are fully equal. Full means the addresses are equal and the lap flags differ.
- R3: `xfer_ack` is `xfer_req` gated by the stall condition in the same cycle. The stall condition is empty on the output side and full on the input side. Each accepted request moves the owned pointer (read on the output side, write on the input side) forward by STEP bytes at the next edge. Without a request or a write, both pointers hold.
- R4: When a step would move the address beyond the last byte, the address restarts at base and bit 31 inverts.
- R5: A refused request leaves the pointers unchanged. It gives a one-cycle pulse in the next cycle, on `underflow_o` for the output side or on `overflow_o` for the input side. The other error port stays 0.
- R6: When armed, a watched count strictly greater than the threshold gives a one-cycle `mark_evt_o` pulse in the cycle after that count appears. A count equal to the threshold gives no pulse.
- R7: After an event the logic stays disarmed until a `mark_rearm` pulse. If the condition still holds when it is armed again, it fires again.
- R8: Writing the read pointer with bit 31 inverted into the write pointer restarts an output period as full. Copying the write pointer into the read pointer restarts an input period as empty.
- R9: A software write to the owned pointer in the same cycle as an accepted request wins, and the step is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select (R2 codes) |
| cfg_wdata | input | PTR_W | Configuration write data |
| mark_rearm | input | 1 | Arms the threshold event |
| xfer_req | input | 1 | Hardware request to step the owned pointer |
| xfer_ack | output | 1 | Request accepted this cycle |
| rd_ptr_o | output | PTR_W | Read pointer with lap flag |
| wr_ptr_o | output | PTR_W | Write pointer with lap flag |
| level_o | output | PTR_W | Filled bytes |
| free_o | output | PTR_W | Free bytes |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full |
| mark_evt_o | output | 1 | One-shot threshold event pulse |
| underflow_o | output | 1 | Output-side refused request pulse |
| overflow_o | output | 1 | Input-side refused request pulse |

## Verification
If the lap flag is wrong, full and empty swap, and the level jumps by a whole buffer size in the same cycle the pointer moves. This shows up at the latest on the step that returns to base. If the arm flag is wrong, the event either repeats in back-to-back cycles or never comes. The bench therefore counts event pulses at exact step counts on both sides of the threshold, and again after each re-arm. If the stall condition is wrong, the bench sees it in the same cycle as `xfer_ack` when it requests from an empty or full buffer. One cycle later it sees the pointer value and the error pulse.

// File: rtl/rbuf_pkg.sv
`timescale 1ns/1ps
package rbuf_pkg;
   typedef enum logic [2:0] {
      SEL_BASE = 3'd0,
      SEL_LAST = 3'd1,
      SEL_RD   = 3'd2,
      SEL_WR   = 3'd3,
      SEL_MARK = 3'd4
   } cfg_sel_e;
endpackage

// File: rtl/rbuf_step.sv
`timescale 1ns/1ps
// Next value of a lapping pointer after one step of STEP bytes.
module rbuf_step #(
   parameter int PTR_W = 32,
   parameter int STEP  = 4,
   localparam int ADDR_W = PTR_W - 1,
   localparam int LW     = ADDR_W + 1
) (
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] last_i,
   output logic [PTR_W-1:0]  nxt_o
);
   logic [LW-1:0] sum;

   always_comb begin
      sum = {1'b0, ptr_i[ADDR_W-1:0]} + LW'(STEP);
      if (sum > {1'b0, last_i})
         nxt_o = {~ptr_i[PTR_W-1], base_i};
      else
         nxt_o = {ptr_i[PTR_W-1], sum[ADDR_W-1:0]};
   end
endmodule

// File: rtl/rbuf_level.sv
`timescale 1ns/1ps
// Fill, free and full/empty flags derived from two lapping pointers.
module rbuf_level #(
   parameter int PTR_W = 32,
   localparam int ADDR_W = PTR_W - 1,
   localparam int LW     = ADDR_W + 1
) (
   input  logic [PTR_W-1:0]  rd_i,
   input  logic [PTR_W-1:0]  wr_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] last_i,
   output logic [LW-1:0]     size_o,
   output logic [LW-1:0]     fill_o,
   output logic [LW-1:0]     free_o,
   output logic              empty_o,
   output logic              full_o
);
   logic [LW-1:0] ra, wa;
   logic          same_lap, same_addr;

   always_comb begin
      ra        = {1'b0, rd_i[ADDR_W-1:0]};
      wa        = {1'b0, wr_i[ADDR_W-1:0]};
      size_o    = {1'b0, last_i} - {1'b0, base_i} + LW'(1);
      same_lap  = (rd_i[PTR_W-1] == wr_i[PTR_W-1]);
      same_addr = (ra == wa);
      empty_o   = same_lap & same_addr;
      full_o    = ~same_lap & same_addr;
      fill_o    = same_lap ? (wa - ra) : (size_o - (ra - wa));
      free_o    = size_o - fill_o;
   end
endmodule

// File: rtl/rbuf_event.sv
`timescale 1ns/1ps
// One-shot threshold event with software re-arm, plus registered error pulse.
module rbuf_event #(
   parameter int LW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] metric_i,
   input  logic [LW-1:0] thresh_i,
   input  logic          rearm_i,
   input  logic          refused_i,
   output logic          mark_o,
   output logic          err_o
);
   logic armed_q;
   logic fire;

   assign fire = armed_q && (metric_i > thresh_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         mark_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         armed_q <= rearm_i | (armed_q & ~fire);
         mark_o  <= fire;
         err_o   <= refused_i;
      end
   end

   // An event is never followed directly by another unless re-armed in between
   p_mark_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_o && !$past(rearm_i)) |=> !mark_o);

   // Error pulse only follows a refused request
   p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(refused_i));

   // Event implies the count was above threshold the cycle before
   p_mark_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mark_o |-> $past(metric_i > thresh_i));
endmodule

// File: rtl/rbuf_ptr_mark.sv
`timescale 1ns/1ps
module rbuf_ptr_mark
   import rbuf_pkg::*;
#(
   parameter int PTR_W    = 32,
   parameter int STEP     = 4,
   parameter int MARK_LSB = 8,
   parameter bit PLAYBACK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [PTR_W-1:0] cfg_wdata,
   input  logic             mark_rearm,
   input  logic             xfer_req,
   output logic             xfer_ack,
   output logic [PTR_W-1:0] rd_ptr_o,
   output logic [PTR_W-1:0] wr_ptr_o,
   output logic [PTR_W-1:0] level_o,
   output logic [PTR_W-1:0] free_o,
   output logic             empty_o,
   output logic             full_o,
   output logic             mark_evt_o,
   output logic             underflow_o,
   output logic             overflow_o
);
   localparam int ADDR_W = PTR_W - 1;
   localparam int LW     = ADDR_W + 1;
   localparam int MW     = ADDR_W - MARK_LSB;

   generate
      if (PTR_W < 8)
         $error("rbuf_ptr_mark: PTR_W must be at least 8");
      if (STEP < 1 || (STEP & (STEP - 1)) != 0)
         $error("rbuf_ptr_mark: STEP must be a power of two");
      if (MARK_LSB < 0 || MARK_LSB >= ADDR_W)
         $error("rbuf_ptr_mark: MARK_LSB out of range");
   endgenerate

   cfg_sel_e sel;
   assign sel = cfg_sel_e'(cfg_sel);

   logic [ADDR_W-1:0] base_q, last_q;
   logic [PTR_W-1:0]  rd_q, wr_q;
   logic [MW-1:0]     mark_q;

   logic wr_base, wr_last, wr_rd, wr_wr, wr_mark;
   assign wr_base = cfg_we && (sel == SEL_BASE);
   assign wr_last = cfg_we && (sel == SEL_LAST);
   assign wr_rd   = cfg_we && (sel == SEL_RD);
   assign wr_wr   = cfg_we && (sel == SEL_WR);
   assign wr_mark = cfg_we && (sel == SEL_MARK);

   logic [LW-1:0] size, fill, free;
   logic          empty, full;

   rbuf_level #(.PTR_W(PTR_W)) u_lvl (
      .rd_i    (rd_q),
      .wr_i    (wr_q),
      .base_i  (base_q),
      .last_i  (last_q),
      .size_o  (size),
      .fill_o  (fill),
      .free_o  (free),
      .empty_o (empty),
      .full_o  (full)
   );

   logic [PTR_W-1:0] cons_ptr, cons_nxt;
   logic [LW-1:0]    metric, thresh;
   logic             stall, adv_rd, adv_wr, err;

   rbuf_step #(.PTR_W(PTR_W), .STEP(STEP)) u_step (
      .ptr_i  (cons_ptr),
      .base_i (base_q),
      .last_i (last_q),
      .nxt_o  (cons_nxt)
   );

   assign xfer_ack = xfer_req & ~stall;
   assign thresh   = {1'b0, mark_q, {MARK_LSB{1'b0}}};

   generate
      if (PLAYBACK) begin : g_drain
         assign cons_ptr    = rd_q;
         assign stall       = empty;
         assign metric      = free;
         assign adv_rd      = xfer_ack;
         assign adv_wr      = 1'b0;
         assign underflow_o = err;
         assign overflow_o  = 1'b0;
      end else begin : g_fill
         assign cons_ptr    = wr_q;
         assign stall       = full;
         assign metric      = fill;
         assign adv_rd      = 1'b0;
         assign adv_wr      = xfer_ack;
         assign underflow_o = 1'b0;
         assign overflow_o  = err;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         last_q <= '0;
         rd_q   <= '0;
         wr_q   <= '0;
         mark_q <= '0;
      end else begin
         if (wr_base) base_q <= cfg_wdata[ADDR_W-1:0];
         if (wr_last) last_q <= cfg_wdata[ADDR_W-1:0];
         if (wr_mark) mark_q <= cfg_wdata[ADDR_W-1:MARK_LSB];
         if (wr_rd)       rd_q <= cfg_wdata;
         else if (adv_rd) rd_q <= cons_nxt;
         if (wr_wr)       wr_q <= cfg_wdata;
         else if (adv_wr) wr_q <= cons_nxt;
      end
   end

   rbuf_event #(.LW(LW)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .metric_i  (metric),
      .thresh_i  (thresh),
      .rearm_i   (mark_rearm),
      .refused_i (xfer_req & stall),
      .mark_o    (mark_evt_o),
      .err_o     (err)
   );

   assign rd_ptr_o = rd_q;
   assign wr_ptr_o = wr_q;
   assign level_o  = fill;
   assign free_o   = free;
   assign empty_o  = empty;
   assign full_o   = full;

   // Accepted request without a software write always moves the owned pointer
   p_adv_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ack && !cfg_we) |=> (cons_ptr != $past(cons_ptr)));

   // No request, no write: pointers hold
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_req && !cfg_we) |=> ($stable(rd_q) && $stable(wr_q)));

   // Lap flag flips only on landing at base
   p_wrap_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ack && !cfg_we) |=>
         ((cons_ptr[PTR_W-1] == $past(cons_ptr[PTR_W-1])) ||
          (cons_ptr[ADDR_W-1:0] == base_q)));

   // Software write to the read pointer wins over a step
   p_sw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && sel == SEL_RD) |=> (rd_q == $past(cfg_wdata)));

   // Full reports a whole buffer, empty reports nothing
   p_full_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (fill == size));
   p_empty_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (fill == '0));
endmodule

// File: tb/sim_rbuf_ptr_mark.sv
`timescale 1ns/1ps
module sim_rbuf_ptr_mark;
   import rbuf_pkg::*;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [31:0] cfg_wdata = '0;
   logic        we0 = 0, we1 = 0, rearm0 = 0, rearm1 = 0, req0 = 0, req1 = 0;

   logic        ack0, ack1, emp0, emp1, ful0, ful1, mk0_p, mk1_p;
   logic        uf0_p, uf1_p, of0_p, of1_p;
   logic [31:0] rd0, wr0, lv0, fr0, rd1, wr1, lv1, fr1;

   rbuf_ptr_mark #(.PLAYBACK(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(we0), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .mark_rearm(rearm0), .xfer_req(req0),
      .xfer_ack(ack0), .rd_ptr_o(rd0), .wr_ptr_o(wr0), .level_o(lv0),
      .free_o(fr0), .empty_o(emp0), .full_o(ful0), .mark_evt_o(mk0_p),
      .underflow_o(uf0_p), .overflow_o(of0_p));

   rbuf_ptr_mark #(.PLAYBACK(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_we(we1), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .mark_rearm(rearm1), .xfer_req(req1),
      .xfer_ack(ack1), .rd_ptr_o(rd1), .wr_ptr_o(wr1), .level_o(lv1),
      .free_o(fr1), .empty_o(emp1), .full_o(ful1), .mark_evt_o(mk1_p),
      .underflow_o(uf1_p), .overflow_o(of1_p));

   typedef struct {
      int     cyc;
      int     sig;
      longint val;
      string  req;
   } item_t;

   item_t q[$];
   item_t it_m;
   int cyc = 0;
   int checks = 0, failures = 0;
   int mk0 = 0, uf0 = 0, of0 = 0, mk1 = 0, uf1 = 0, of1 = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic longint get(int s);
      case (s)
         0:  return longint'(rd0);
         1:  return longint'(wr0);
         2:  return longint'(lv0);
         3:  return longint'(ful0);
         4:  return longint'(emp0);
         5:  return longint'(ack0);
         6:  return longint'(mk0);
         7:  return longint'(uf0);
         8:  return longint'(of0);
         9:  return longint'(fr0);
         10: return longint'(rd1);
         11: return longint'(wr1);
         12: return longint'(lv1);
         13: return longint'(ful1);
         14: return longint'(emp1);
         15: return longint'(ack1);
         16: return longint'(mk1);
         17: return longint'(uf1);
         18: return longint'(of1);
         default: return longint'(fr1);
      endcase
   endfunction

   // Monitor: count pulses, then compare due scoreboard items
   always @(negedge clk) begin
      if (!rst_n) begin
         mk0 = 0; uf0 = 0; of0 = 0; mk1 = 0; uf1 = 0; of1 = 0;
      end else begin
         if (mk0_p) mk0++;
         if (uf0_p) uf0++;
         if (of0_p) of0++;
         if (mk1_p) mk1++;
         if (uf1_p) uf1++;
         if (of1_p) of1++;
      end
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         it_m = q.pop_front();
         checks++;
         if (get(it_m.sig) !== it_m.val) begin
            failures++;
            $display("FAIL %s sig=%0d actual=0x%0h expected=0x%0h",
                     it_m.req, it_m.sig, get(it_m.sig), it_m.val);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_now(int s, longint v, string r);
      q.push_back('{cyc, s, v, r});
   endtask

   task automatic cfg(bit inst, cfg_sel_e sel, logic [31:0] d);
      cfg_sel   = sel;
      cfg_wdata = d;
      if (inst) we1 = 1; else we0 = 1;
      tick();
      we0 = 0;
      we1 = 0;
   endtask

   task automatic reqs(bit inst, int n);
      for (int i = 0; i < n; i++) begin
         if (inst) req1 = 1; else req0 = 1;
         tick();
      end
      req0 = 0;
      req1 = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic rearm(bit inst);
      if (inst) rearm1 = 1; else rearm0 = 1;
      tick();
      rearm0 = 0;
      rearm1 = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      tick();
      // R1 reset state
      expect_now(0, 0, "R1 rd reset");
      expect_now(1, 0, "R1 wr reset");
      expect_now(2, 0, "R1 level reset");
      expect_now(4, 1, "R1 empty reset");
      expect_now(3, 0, "R1 full reset");
      expect_now(14, 1, "R1 empty reset capture");

      // ---- output side (u0) ----
      cfg(0, SEL_BASE, 32'h8000_1000);
      cfg(0, SEL_LAST, 32'h0000_13FF);
      cfg(0, SEL_MARK, 32'h0000_01FF);
      cfg(0, SEL_RD,   32'h0000_1000);
      cfg(0, SEL_WR,   32'h8000_1000);
      expect_now(3, 1, "R2 full after config");
      expect_now(2, 1024, "R2 level full");
      expect_now(9, 0, "R2 free full");
      idle(2);
      expect_now(6, 0, "R1 disarmed during config");
      rearm(0);
      req0 = 1;
      expect_now(5, 1, "R3 ack same cycle");
      reqs(0, 64);
      expect_now(0, 32'h0000_1100, "R3 step 4 bytes");
      expect_now(2, 768, "R2 level after steps");
      expect_now(9, 256, "R2 free after steps");
      idle(3);
      expect_now(6, 0, "R6 equal to threshold no event");
      reqs(0, 1);
      idle(3);
      expect_now(6, 1, "R6 event above threshold");
      reqs(0, 10);
      idle(3);
      expect_now(6, 1, "R7 stays disarmed");
      rearm(0);
      idle(3);
      expect_now(6, 2, "R7 refires after rearm");
      reqs(0, 181);
      expect_now(0, 32'h8000_1000, "R4 wrap to base flips lap");
      expect_now(4, 1, "R4 empty after full drain");
      expect_now(2, 0, "R4 level zero");
      req0 = 1;
      expect_now(5, 0, "R5 refused when empty");
      tick();
      req0 = 0;
      expect_now(7, 1, "R5 underflow pulse");
      expect_now(0, 32'h8000_1000, "R5 pointer held");
      expect_now(8, 0, "R5 no overflow on output side");
      cfg(0, SEL_WR, rd0 ^ 32'h8000_0000);
      expect_now(3, 1, "R8 restart full");
      expect_now(2, 1024, "R8 restart level");
      cfg_sel = SEL_RD;
      cfg_wdata = 32'h0000_1200;
      we0 = 1;
      req0 = 1;
      tick();
      we0 = 0;
      req0 = 0;
      expect_now(0, 32'h0000_1200, "R9 write wins over step");

      // ---- input side (u1) ----
      cfg(1, SEL_BASE, 32'h0000_2000);
      cfg(1, SEL_LAST, 32'h0000_20FF);
      cfg(1, SEL_MARK, 32'h0000_0000);
      cfg(1, SEL_RD,   32'h0000_2000);
      cfg(1, SEL_WR,   32'h0000_2000);
      expect_now(14, 1, "R2 capture empty");
      rearm(1);
      idle(2);
      expect_now(16, 0, "R6 capture no event at zero");
      reqs(1, 1);
      expect_now(11, 32'h0000_2004, "R3 capture write step");
      expect_now(12, 4, "R2 capture level");
      idle(3);
      expect_now(16, 1, "R6 capture event");
      reqs(1, 63);
      expect_now(11, 32'h8000_2000, "R4 capture wrap");
      expect_now(13, 1, "R4 capture full");
      expect_now(12, 256, "R4 capture level full");
      req1 = 1;
      expect_now(15, 0, "R5 refused when full");
      tick();
      req1 = 0;
      expect_now(18, 1, "R5 overflow pulse");
      expect_now(17, 0, "R5 no underflow on input side");
      expect_now(11, 32'h8000_2000, "R5 capture pointer held");
      cfg(1, SEL_RD, wr1);
      expect_now(14, 1, "R8 restart empty");
      expect_now(12, 0, "R8 restart level zero");
      idle(2);
      expect_now(16, 1, "R7 capture single event");

      while (q.size() > 0) tick();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule